// File: doc/BRIEF.md
# Standby Release Oscillation-Wait Timer

This block governs a processor's deepest low-power state. When the processor issues a stop command, its clock is shut off and the block parks in a stopped phase. The clock comes back in one of two ways. An interrupt request that is enabled can release it. The active-low reset can also release it, from any phase.

After a release, the block keeps the processor stalled while a counter runs off the restarted clock. This gives the oscillator time to settle before any instruction executes. The length of the wait comes from a 4-bit mode register: two of its bits pick one of four unequal powers of two, and the other two bits are ignored.

An interrupt release goes straight back to running and leaves the mode register untouched. A reset release first clears the mode register, which selects the longest wait. After that wait, a short internal initialisation phase runs before the processor resumes. A scaling parameter shortens every wait by a power of two so that simulation stays short.

Top module: `stby_wake_timer`

## Requirements
- R1: With mode bits [2:1] = 00, 01, 10, 11 the post-release wait phase (phase code 2'b10) lasts exactly 2^20, 2^17, 2^15, 2^13 clock cycles respectively, each divided by 2^SCALE_SHIFT.
- R2: Mode bits 3 and 0 do not change the wait length.
- R3: A one-cycle stop_cmd while running (phase 2'b00) puts the block in the stopped phase (2'b01) on the next cycle, with cpu_run and clk_running both low.
- R4: In the stopped phase, irq_req together with irq_en moves the block to the wait phase on the next cycle. irq_req with irq_en low leaves it stopped. irq_req while running has no effect.
- R5: cpu_run is high only in the run phase. clk_running is low only in the stopped phase.
- R6: While rst_n is low the phase is wait and the mode register reads 4'b0000. After rst_n rises, the wait uses the 2^20 setting, and then an initialisation phase (2'b11) lasts RST_CYCLES cycles before the run phase.
- R7: After an interrupt release the wait ends directly in the run phase, and the mode register keeps its value.
- R8: The wait counter is cleared on entry to the stopped phase, so every release waits the full selected length.
- R9: A further irq_req during the wait does not restart or lengthen it.
- R10: mode_wr loads mode_wdata into the mode register only in the run phase. mode_rd always shows the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also a release event |
| stop_cmd | input | 1 | One-cycle command to enter the stopped phase |
| irq_req | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt enable for release |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | Mode register write data |
| cpu_run | output | 1 | Processor may execute |
| clk_running | output | 1 | Clock is running |
| phase | output | 2 | 00 run, 01 stopped, 10 waiting, 11 initialising |
| mode_rd | output | 4 | Mode register contents |

## Verification
The bench measures the exact wait length for all four selections. A design with an off-by-one compare would give waits one cycle too long or too short, and a design that decoded the wrong bits would change length when bits 3 or 0 are set. Extra interrupts are held through the first cycles of a wait, which exposes a design that restarts its count. A reset during the stopped phase must clear the mode register and add the initialisation phase; a design that kept the old mode would produce a short wait. A masked interrupt and mode writes outside the run phase must leave both the phase and the register unchanged.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [1:0] {
    PH_RUN  = 2'b00,
    PH_STOP = 2'b01,
    PH_WAIT = 2'b10,
    PH_INIT = 2'b11
  } phase_e;

  localparam int unsigned MAX_EXP = 20;

  // Exponent of the settle wait selected by mode bits [2:1].
  function automatic int unsigned wait_exp(input logic [1:0] sel);
    case (sel)
      2'b00:   return 20;
      2'b01:   return 17;
      2'b10:   return 15;
      default: return 13;
    endcase
  endfunction

  function automatic int unsigned scaled_exp(input logic [1:0] sel,
                                             input int unsigned shift);
    return wait_exp(sel) - shift;
  endfunction

endpackage

// File: rtl/stby_mode_reg.sv
module stby_mode_reg #(
  parameter int unsigned MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  logic [MW-1:0] wdata,
  output logic [MW-1:0] mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= '0;
    else if (wr_ok) mode_q <= wdata;
  end

  // R10: without a qualified write the register holds
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(mode_q));

endmodule

// File: rtl/stby_wait_count.sv
module stby_wait_count #(
  parameter int unsigned SHIFT = 0,
  parameter int unsigned CW    = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [1:0]    sel,
  output logic          done,
  output logic [CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_c;

  always_comb begin
    last_c = CW'((64'd1 << stby_pkg::scaled_exp(sel, SHIFT)) - 64'd1);
    done   = run && (cnt_q == last_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R8: a clear leaves the counter at zero
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R9: inside a wait the count only advances by one
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !done) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/stby_phase_fsm.sv
module stby_phase_fsm
  import stby_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   stop_cmd,
  input  logic   irq_req,
  input  logic   irq_en,
  input  logic   wait_done,
  output phase_e phase_q,
  output logic   count_en,
  output logic   count_clr,
  output logic   stop_go,
  output logic   wake_go
);

  localparam int unsigned IW = $clog2(RST_CYCLES) + 1;
  localparam logic [IW-1:0] ILAST = IW'(RST_CYCLES - 1);

  phase_e        phase_d;
  logic          from_rst_q, from_rst_d;
  logic [IW-1:0] icnt_q, icnt_d;
  logic          irq_fire;

  assign irq_fire = irq_req && irq_en;

  always_comb begin
    phase_d    = phase_q;
    from_rst_d = from_rst_q;
    icnt_d     = icnt_q;
    stop_go    = 1'b0;
    wake_go    = 1'b0;
    case (phase_q)
      PH_RUN: begin
        if (stop_cmd) begin
          phase_d = PH_STOP;
          stop_go = 1'b1;
        end
      end
      PH_STOP: begin
        if (irq_fire) begin
          phase_d    = PH_WAIT;
          wake_go    = 1'b1;
          from_rst_d = 1'b0;
        end
      end
      PH_WAIT: begin
        if (wait_done) begin
          if (from_rst_q) begin
            phase_d = PH_INIT;
            icnt_d  = '0;
          end else begin
            phase_d = PH_RUN;
          end
        end
      end
      default: begin
        if (icnt_q == ILAST) begin
          phase_d    = PH_RUN;
          from_rst_d = 1'b0;
        end else begin
          icnt_d = icnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_WAIT;
      from_rst_q <= 1'b1;
      icnt_q     <= '0;
    end else begin
      phase_q    <= phase_d;
      from_rst_q <= from_rst_d;
      icnt_q     <= icnt_d;
    end
  end

  assign count_en  = (phase_q == PH_WAIT);
  assign count_clr = stop_go || wake_go;

  // R3
  a_r3_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN && stop_cmd) |=> (phase_q == PH_STOP));
  // R4
  a_r4_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STOP && irq_req && irq_en) |=> (phase_q == PH_WAIT));
  a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STOP && !(irq_req && irq_en)) |=> (phase_q == PH_STOP));
  // R6
  a_r6_init_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT && wait_done && from_rst_q) |=> (phase_q == PH_INIT));
  // R7
  a_r7_irq_to_run: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT && wait_done && !from_rst_q) |=> (phase_q == PH_RUN));
  // R9
  a_r9_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT && !wait_done) |=> (phase_q == PH_WAIT));

endmodule

// File: rtl/stby_wake_timer.sv
module stby_wake_timer
  import stby_pkg::*;
#(
  parameter int unsigned SCALE_SHIFT = 0,
  parameter int unsigned RST_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_cmd,
  input  logic       irq_req,
  input  logic       irq_en,
  input  logic       mode_wr,
  input  logic [3:0] mode_wdata,
  output logic       cpu_run,
  output logic       clk_running,
  output logic [1:0] phase,
  output logic [3:0] mode_rd
);

  localparam int unsigned MW = 4;
  localparam int unsigned CW = MAX_EXP - SCALE_SHIFT + 1;

  phase_e        phase_q;
  logic          count_en, count_clr, stop_go, wake_go;
  logic          wait_done;
  logic          mode_wr_ok;
  logic [MW-1:0] mode_q;
  logic [CW-1:0] wait_cnt;

  assign mode_wr_ok = mode_wr && (phase_q == PH_RUN);

  stby_mode_reg #(.MW(MW)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ok  (mode_wr_ok),
    .wdata  (mode_wdata),
    .mode_q (mode_q)
  );

  stby_wait_count #(.SHIFT(SCALE_SHIFT), .CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (count_clr),
    .run   (count_en),
    .sel   (mode_q[2:1]),
    .done  (wait_done),
    .cnt_o (wait_cnt)
  );

  stby_phase_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_cmd  (stop_cmd),
    .irq_req   (irq_req),
    .irq_en    (irq_en),
    .wait_done (wait_done),
    .phase_q   (phase_q),
    .count_en  (count_en),
    .count_clr (count_clr),
    .stop_go   (stop_go),
    .wake_go   (wake_go)
  );

  assign cpu_run     = (phase_q == PH_RUN);
  assign clk_running = (phase_q != PH_STOP);
  assign phase       = phase_q;
  assign mode_rd     = mode_q;

  // R5
  a_r5_run_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_run |-> clk_running);
  // R8
  a_r8_stopped_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STOP) |-> (wait_cnt == '0));
  // R10
  a_r10_no_write_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_RUN) |=> $stable(mode_rd));

endmodule

// File: tb/stby_wake_timer_test.sv
`timescale 1ns/1ps
module stby_wake_timer_test;

  localparam int unsigned SHIFT = 10;
  localparam int unsigned RSTC  = 4;
  localparam int NV = 8;
  // [15:12] mode, [11] extra irq during wait, [10:0] expected wait length
  localparam logic [15:0] VEC [NV] = '{
    {4'b0010, 1'b0, 11'd128},
    {4'b0100, 1'b0, 11'd32},
    {4'b0110, 1'b0, 11'd8},
    {4'b1101, 1'b0, 11'd32},
    {4'b1011, 1'b0, 11'd128},
    {4'b0110, 1'b1, 11'd8},
    {4'b0100, 1'b1, 11'd32},
    {4'b0000, 1'b0, 11'd1024}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_cmd = 1'b0, irq_req = 1'b0, irq_en = 1'b1, mode_wr = 1'b0;
  logic [3:0] mode_wdata = '0;
  logic cpu_run, clk_running;
  logic [1:0] phase;
  logic [3:0] mode_rd;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  stby_wake_timer #(.SCALE_SHIFT(SHIFT), .RST_CYCLES(RSTC)) uut (
    .clk, .rst_n, .stop_cmd, .irq_req, .irq_en, .mode_wr, .mode_wdata,
    .cpu_run, .clk_running, .phase, .mode_rd
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input logic [1:0] ph, input bit hold, output int n);
    n = 0;
    while (phase == ph && n < 5000) begin
      n++;
      if (!(hold && n < 5)) irq_req = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic write_mode(input logic [3:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_cmd = 1'b1;
    @(negedge clk); stop_cmd = 1'b0;
    chk("R3 phase stopped", phase, 1);
    chk("R3 cpu_run low", cpu_run, 0);
    chk("R3 clk_running low", clk_running, 0);
  endtask

  task automatic do_wake(input bit hold, output int n);
    @(negedge clk); irq_req = 1'b1; irq_en = 1'b1;
    @(negedge clk);
    chk("R4 wake to wait", phase, 2);
    chk("R5 clock on in wait", clk_running, 1);
    chk("R5 stalled in wait", cpu_run, 0);
    measure(2'b10, hold, n);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R6 reset phase wait", phase, 2);
    chk("R6 reset mode zero", mode_rd, 0);
    chk("R5 reset stalled", cpu_run, 0);
    rst_n = 1'b1;
    measure(2'b10, 1'b0, n);
    chk("R6 reset wait length", n, 1024);
    measure(2'b11, 1'b0, n);
    chk("R6 init length", n, RSTC);
    chk("R6 then run", phase, 0);
    chk("R5 run enable", cpu_run, 1);

    // R4: interrupt while running is ignored
    @(negedge clk); irq_req = 1'b1;
    @(negedge clk); irq_req = 1'b0;
    chk("R4 irq in run ignored", phase, 0);

    for (int i = 0; i < NV; i++) begin
      write_mode(VEC[i][15:12]);
      chk("R10 mode write", mode_rd, VEC[i][15:12]);
      do_stop();
      do_wake(VEC[i][11], n);
      if (VEC[i][11]) chk("R9 extra irq wait length", n, VEC[i][10:0]);
      else if (VEC[i][12] || VEC[i][15]) chk("R2 ignored bits length", n, VEC[i][10:0]);
      else chk("R1 wait length", n, VEC[i][10:0]);
      chk("R7 irq release to run", phase, 0);
      chk("R7 mode kept", mode_rd, VEC[i][15:12]);
    end

    // R8: repeated release gives the full wait again
    do_stop();
    do_wake(1'b0, n);
    chk("R8 full wait again", n, 1024);

    // R4 masked interrupt, R10 write while stopped
    write_mode(4'b0110);
    do_stop();
    @(negedge clk); irq_en = 1'b0; irq_req = 1'b1;
    mode_wr = 1'b1; mode_wdata = 4'b1001;
    repeat (20) @(negedge clk);
    mode_wr = 1'b0; irq_req = 1'b0;
    chk("R4 masked irq stays stopped", phase, 1);
    chk("R10 write ignored when stopped", mode_rd, 4'b0110);
    do_wake(1'b0, n);
    chk("R10 wait uses kept mode", n, 8);

    // R6: reset during stopped phase
    write_mode(4'b0100);
    do_stop();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R6 reset clears mode", mode_rd, 0);
    chk("R6 reset gives wait", phase, 2);
    rst_n = 1'b1;
    measure(2'b10, 1'b0, n);
    chk("R6 reset wait uses 2^20 setting", n, 1024);
    measure(2'b11, 1'b0, n);
    chk("R6 init after reset", n, RSTC);
    chk("R6 run after init", phase, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule